// File: doc/BRIEF.md
# Stereo Audio Stream Register Slave

This block sits on a processor's AXI4-Lite bus and gives software a word-wide path to two audio sample queues: a playback queue that feeds a codec and a capture queue filled by it. Each queue word carries one stereo frame. The right-channel sample is a signed 16-bit value in bits 31:16 and the left-channel sample is a signed 16-bit value in bits 15:0. The block passes words through unchanged in both directions.

Software sees a window of 16 word registers, of which three are decoded. Word 0 is control on write and status on read. Word 1 is the playback push port. Word 2 is the capture pop port. A read of word 2 removes one frame from the capture queue, so the block pops exactly once for each read transaction, however long the master stalls the read data. Control writes do not store anything. They produce one-cycle reset strobes towards the queues. The queues themselves, the clock-domain crossing and the codec link are outside this block. The capture queue is expected to show its head word on its data port while it is not empty.

Top module: `audio_fifo_regs`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every AXI ready and valid output, every queue strobe (push, pop, both resets) and the interrupt output are 0.
- R2: After AWVALID and WVALID are both high, AWREADY and WREADY rise together on the next cycle for exactly one cycle. BVALID rises the cycle after that handshake with BRESP = 00 (OKAY) and stays high until BREADY.
- R3: A write to byte offset 0x4 with the playback queue not full gives exactly one one-cycle push strobe, with the playback data equal to the written 32-bit word (right sample in 31:16, left sample in 15:0).
- R4: A write to offset 0x4 while the playback full input is high gives no push strobe and still completes with OKAY.
- R5: A write to offset 0x0 gives a one-cycle playback reset strobe if data bit 0 is 1 and a one-cycle capture reset strobe if data bit 1 is 1. The value 3 gives both. Nothing is stored, so status bits 1:0 read back as 0.
- R6: A read of offset 0x0 returns capture empty in bit 2, playback empty in bit 3, capture full in bit 4 and playback full in bit 5, each 1 when true. All other bits are 0.
- R7: A read of offset 0x8 while the capture queue is not empty returns the capture head word and gives exactly one one-cycle pop strobe. This holds however many cycles RREADY stays low, and RDATA stays stable while RVALID waits for RREADY.
- R8: A read of offset 0x8 while the capture queue is empty returns 0 with OKAY and gives no pop strobe.
- R9: Writes to any offset other than 0x0 and 0x4, including addresses not aligned to a word, complete with OKAY and give no strobe. Reads from any offset other than 0x0 and 0x8 return 0 and give no pop strobe.
- R10: The interrupt output is 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awaddr | input | ADDR_W | Write address (byte) |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | DATA_W | Write data |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address (byte) |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| play_data | output | DATA_W | Frame pushed to the playback queue |
| play_wr | output | 1 | Playback push strobe |
| play_full | input | 1 | Playback queue full |
| play_empty | input | 1 | Playback queue empty |
| play_rst | output | 1 | Playback queue reset strobe |
| cap_data | input | DATA_W | Capture queue head word |
| cap_rd | output | 1 | Capture pop strobe |
| cap_full | input | 1 | Capture queue full |
| cap_empty | input | 1 | Capture queue empty |
| cap_rst | output | 1 | Capture queue reset strobe |
| irq | output | 1 | Interrupt, tied low |

## Verification
The assertions check the following on every cycle. A ready pulse lasts one cycle and is followed by a response. A pending response is held. Every reset strobe and every pop strobe lasts one cycle. A pop never follows an empty capture flag, and it only occurs together with a pending read response. Read data stays frozen while RVALID waits. Whether the right strobe follows a given offset and data bit, the status bit layout, the zero returned from undecoded or empty reads, and the exact pop count across a long RREADY stall can only be shown by the bench's scenarios. The bench compares the strobe counts and returned words against expected values worked out from the requirements.

// File: rtl/afr_pkg.sv
package afr_pkg;
  localparam int unsigned REG_CTRL = 0;
  localparam int unsigned REG_PLAY = 1;
  localparam int unsigned REG_CAP  = 2;
  localparam int STAT_CAP_EMPTY  = 2;
  localparam int STAT_PLAY_EMPTY = 3;
  localparam int STAT_CAP_FULL   = 4;
  localparam int STAT_PLAY_FULL  = 5;
  localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/afr_wr_path.sv
module afr_wr_path #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              awvalid,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wvalid,
  input  logic              bready,
  input  logic              play_full,
  output logic              addr_ready,
  output logic              bvalid,
  output logic [DATA_W-1:0] play_data,
  output logic              play_wr,
  output logic              play_rst,
  output logic              cap_rst
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] I_CTRL = IDX_W'(afr_pkg::REG_CTRL);
  localparam logic [IDX_W-1:0] I_PLAY = IDX_W'(afr_pkg::REG_PLAY);

  logic             accept_q;
  logic             aligned;
  logic [IDX_W-1:0] idx;

  assign aligned    = (awaddr[1:0] == 2'b00);
  assign idx        = awaddr[ADDR_W-1:2];
  assign addr_ready = accept_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      accept_q  <= 1'b0;
      bvalid    <= 1'b0;
      play_data <= '0;
      play_wr   <= 1'b0;
      play_rst  <= 1'b0;
      cap_rst   <= 1'b0;
    end else begin
      play_wr  <= 1'b0;
      play_rst <= 1'b0;
      cap_rst  <= 1'b0;
      if (accept_q) begin
        accept_q <= 1'b0;
        bvalid   <= 1'b1;
        if (aligned && idx == I_CTRL) begin
          play_rst <= wdata[0];
          cap_rst  <= wdata[1];
        end else if (aligned && idx == I_PLAY && !play_full) begin
          play_wr   <= 1'b1;
          play_data <= wdata;
        end
      end else if (awvalid && wvalid && !bvalid) begin
        accept_q <= 1'b1;
      end
      if (bvalid && bready) bvalid <= 1'b0;
    end
  end

  assert_ready_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    addr_ready |=> !addr_ready && bvalid);
  assert_bresp_hold_R2: assert property (@(posedge clk) disable iff (rst)
    bvalid && !bready |=> bvalid);
  assert_no_push_full_R4: assert property (@(posedge clk) disable iff (rst)
    play_wr |-> !$past(play_full));
  assert_play_rst_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    play_rst |=> !play_rst);
  assert_cap_rst_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    cap_rst |=> !cap_rst);
endmodule

// File: rtl/afr_rd_path.sv
module afr_rd_path #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] araddr,
  input  logic              arvalid,
  input  logic              rready,
  input  logic [DATA_W-1:0] cap_data,
  input  logic              cap_empty,
  input  logic              cap_full,
  input  logic              play_empty,
  input  logic              play_full,
  output logic              arready,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata,
  output logic              cap_rd
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] I_CTRL = IDX_W'(afr_pkg::REG_CTRL);
  localparam logic [IDX_W-1:0] I_CAP  = IDX_W'(afr_pkg::REG_CAP);

  logic              aligned;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] status;
  logic [DATA_W-1:0] rd_value;
  logic              pop_now;

  assign aligned = (araddr[1:0] == 2'b00);
  assign idx     = araddr[ADDR_W-1:2];

  always_comb begin
    status = '0;
    status[afr_pkg::STAT_CAP_EMPTY]  = cap_empty;
    status[afr_pkg::STAT_PLAY_EMPTY] = play_empty;
    status[afr_pkg::STAT_CAP_FULL]   = cap_full;
    status[afr_pkg::STAT_PLAY_FULL]  = play_full;
  end

  always_comb begin
    rd_value = '0;
    pop_now  = 1'b0;
    if (aligned && idx == I_CTRL) begin
      rd_value = status;
    end else if (aligned && idx == I_CAP && !cap_empty) begin
      rd_value = cap_data;
      pop_now  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      arready <= 1'b0;
      rvalid  <= 1'b0;
      rdata   <= '0;
      cap_rd  <= 1'b0;
    end else begin
      cap_rd <= 1'b0;
      if (arready) begin
        arready <= 1'b0;
        rvalid  <= 1'b1;
        rdata   <= rd_value;
        cap_rd  <= pop_now;
      end else if (arvalid && !rvalid) begin
        arready <= 1'b1;
      end
      if (rvalid && rready) rvalid <= 1'b0;
    end
  end

  assert_pop_single_R7: assert property (@(posedge clk) disable iff (rst)
    cap_rd |=> !cap_rd);
  assert_pop_with_resp_R7: assert property (@(posedge clk) disable iff (rst)
    cap_rd |-> rvalid);
  assert_rdata_hold_R7: assert property (@(posedge clk) disable iff (rst)
    rvalid && !rready |=> rvalid && $stable(rdata));
  assert_no_pop_empty_R8: assert property (@(posedge clk) disable iff (rst)
    cap_rd |-> !$past(cap_empty));
  assert_ar_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    arready |=> !arready && rvalid);
endmodule

// File: rtl/audio_fifo_regs.sv
module audio_fifo_regs #(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = $clog2(NUM_REGS) + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [DATA_W-1:0] play_data,
  output logic              play_wr,
  input  logic              play_full,
  input  logic              play_empty,
  output logic              play_rst,
  input  logic [DATA_W-1:0] cap_data,
  output logic              cap_rd,
  input  logic              cap_full,
  input  logic              cap_empty,
  output logic              cap_rst,
  output logic              irq
);
  logic wr_ready;

  afr_wr_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk(clk), .rst(rst),
    .awaddr(s_awaddr), .awvalid(s_awvalid),
    .wdata(s_wdata), .wvalid(s_wvalid),
    .bready(s_bready), .play_full(play_full),
    .addr_ready(wr_ready), .bvalid(s_bvalid),
    .play_data(play_data), .play_wr(play_wr),
    .play_rst(play_rst), .cap_rst(cap_rst)
  );

  afr_rd_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst),
    .araddr(s_araddr), .arvalid(s_arvalid), .rready(s_rready),
    .cap_data(cap_data), .cap_empty(cap_empty), .cap_full(cap_full),
    .play_empty(play_empty), .play_full(play_full),
    .arready(s_arready), .rvalid(s_rvalid), .rdata(s_rdata),
    .cap_rd(cap_rd)
  );

  assign s_awready = wr_ready;
  assign s_wready  = wr_ready;
  assign s_bresp   = afr_pkg::RESP_OKAY;
  assign s_rresp   = afr_pkg::RESP_OKAY;
  assign irq       = 1'b0;
endmodule

// File: tb/tb_audio_fifo_regs.sv
`timescale 1ns/1ps
module tb_audio_fifo_regs;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [5:0]  s_awaddr = '0, s_araddr = '0;
  logic        s_awvalid = 0, s_wvalid = 0, s_bready = 0, s_arvalid = 0, s_rready = 0;
  logic [31:0] s_wdata = '0, cap_data = '0;
  logic        play_full = 0, play_empty = 0, cap_full = 0, cap_empty = 0;
  logic        s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
  logic [1:0]  s_bresp, s_rresp;
  logic [31:0] s_rdata, play_data;
  logic        play_wr, play_rst, cap_rd, cap_rst, irq;

  audio_fifo_regs dut (
    .clk(clk), .rst(rst),
    .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
    .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
    .play_data(play_data), .play_wr(play_wr), .play_full(play_full),
    .play_empty(play_empty), .play_rst(play_rst),
    .cap_data(cap_data), .cap_rd(cap_rd), .cap_full(cap_full),
    .cap_empty(cap_empty), .cap_rst(cap_rst), .irq(irq)
  );

  int errors = 0, checks = 0;
  int n_pw = 0, n_prst = 0, n_crst = 0, n_pop = 0;
  logic [31:0] last_pd = '0;

  always @(negedge clk) if (!rst) begin
    if (play_wr) begin n_pw++; last_pd = play_data; end
    if (play_rst) n_prst++;
    if (cap_rst) n_crst++;
    if (cap_rd) n_pop++;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic axi_write(input string req, input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    s_awaddr = a; s_wdata = d; s_awvalid = 1; s_wvalid = 1; s_bready = 0;
    @(negedge clk);
    chk("R2", "awready", s_awready, 1); chk("R2", "wready", s_wready, 1);
    @(negedge clk);
    s_awvalid = 0; s_wvalid = 0;
    chk("R2", "ready drop", {s_awready, s_wready}, 0);
    chk("R2", "bvalid", s_bvalid, 1);
    chk(req, "bresp", s_bresp, 0);
    @(negedge clk);
    chk("R2", "bvalid held", s_bvalid, 1);
    s_bready = 1;
    @(negedge clk);
    s_bready = 0;
    chk("R2", "bvalid clear", s_bvalid, 0);
  endtask

  task automatic axi_read(input string req, input logic [5:0] a, input int stall, output logic [31:0] d);
    @(negedge clk);
    s_araddr = a; s_arvalid = 1; s_rready = 0;
    @(negedge clk);
    chk(req, "arready", s_arready, 1);
    @(negedge clk);
    s_arvalid = 0;
    chk(req, "rvalid", s_rvalid, 1);
    chk(req, "rresp", s_rresp, 0);
    d = s_rdata;
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      chk("R7", "rdata stable", s_rdata, d);
    end
    s_rready = 1;
    @(negedge clk);
    s_rready = 0;
    chk(req, "rvalid clear", s_rvalid, 0);
  endtask

  typedef struct packed {
    logic [3:0]  req;
    logic        rd;
    logic [5:0]  addr;
    logic [31:0] wdata;
    logic        pfull, pempty, cfull, cempty;
    logic [31:0] cdata;
    logic        pw, prst, crst, pop;
    logic [31:0] rdata;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VT [NV] = '{
    '{4'd3, 1'b0, 6'h04, 32'hABCD_1234, 1'b0,1'b0,1'b0,1'b0, 32'h0,         1'b1,1'b0,1'b0,1'b0, 32'h0},
    '{4'd4, 1'b0, 6'h04, 32'h8000_7FFF, 1'b1,1'b0,1'b0,1'b0, 32'h0,         1'b0,1'b0,1'b0,1'b0, 32'h0},
    '{4'd5, 1'b0, 6'h00, 32'h0000_0001, 1'b0,1'b0,1'b0,1'b0, 32'h0,         1'b0,1'b1,1'b0,1'b0, 32'h0},
    '{4'd5, 1'b0, 6'h00, 32'h0000_0002, 1'b0,1'b0,1'b0,1'b0, 32'h0,         1'b0,1'b0,1'b1,1'b0, 32'h0},
    '{4'd5, 1'b0, 6'h00, 32'h0000_0003, 1'b0,1'b0,1'b0,1'b0, 32'h0,         1'b0,1'b1,1'b1,1'b0, 32'h0},
    '{4'd9, 1'b0, 6'h0C, 32'h0000_0003, 1'b0,1'b0,1'b0,1'b0, 32'h0,         1'b0,1'b0,1'b0,1'b0, 32'h0},
    '{4'd9, 1'b0, 6'h05, 32'h0000_1233, 1'b0,1'b0,1'b0,1'b0, 32'h0,         1'b0,1'b0,1'b0,1'b0, 32'h0},
    '{4'd7, 1'b1, 6'h08, 32'h0,         1'b0,1'b0,1'b0,1'b0, 32'hFFFE_0002, 1'b0,1'b0,1'b0,1'b1, 32'hFFFE_0002},
    '{4'd8, 1'b1, 6'h08, 32'h0,         1'b0,1'b0,1'b0,1'b1, 32'h0000_1111, 1'b0,1'b0,1'b0,1'b0, 32'h0},
    '{4'd6, 1'b1, 6'h00, 32'h0,         1'b1,1'b0,1'b0,1'b1, 32'h0,         1'b0,1'b0,1'b0,1'b0, 32'h0000_0024},
    '{4'd6, 1'b1, 6'h00, 32'h0,         1'b0,1'b1,1'b1,1'b0, 32'h0,         1'b0,1'b0,1'b0,1'b0, 32'h0000_0018},
    '{4'd9, 1'b1, 6'h3C, 32'h0,         1'b0,1'b0,1'b0,1'b0, 32'h0000_5555, 1'b0,1'b0,1'b0,1'b0, 32'h0}
  };

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    int p0, w0, r0, c0;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk("R1", "rst ready/valid", {s_awready, s_wready, s_bvalid, s_arready, s_rvalid}, 0);
    chk("R1", "rst strobes", {play_wr, play_rst, cap_rst, cap_rd, irq}, 0);
    rst = 0;
    @(negedge clk);
    chk("R1", "post-rst ready/valid", {s_awready, s_wready, s_bvalid, s_arready, s_rvalid}, 0);
    chk("R1", "post-rst strobes", {play_wr, play_rst, cap_rst, cap_rd, irq}, 0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d", VT[i].req);
      play_full = VT[i].pfull; play_empty = VT[i].pempty;
      cap_full = VT[i].cfull; cap_empty = VT[i].cempty; cap_data = VT[i].cdata;
      w0 = n_pw; p0 = n_prst; c0 = n_crst; r0 = n_pop;
      if (VT[i].rd) begin
        axi_read(tag, VT[i].addr, 1, d);
        chk(tag, "rdata", d, VT[i].rdata);
      end else begin
        axi_write(tag, VT[i].addr, VT[i].wdata);
      end
      repeat (2) @(negedge clk);
      chk(tag, "push count", n_pw - w0, 32'(VT[i].pw));
      chk(tag, "play rst count", n_prst - p0, 32'(VT[i].prst));
      chk(tag, "cap rst count", n_crst - c0, 32'(VT[i].crst));
      chk(tag, "pop count", n_pop - r0, 32'(VT[i].pop));
      if (VT[i].pw) chk(tag, "play data", last_pd, VT[i].wdata);
    end

    // R7: long RREADY stall, one pop only
    play_full = 0; play_empty = 0; cap_full = 0; cap_empty = 0;
    cap_data = 32'h1357_9BDF;
    r0 = n_pop;
    axi_read("R7", 6'h08, 7, d);
    repeat (2) @(negedge clk);
    chk("R7", "stalled rdata", d, 32'h1357_9BDF);
    chk("R7", "stalled pop count", n_pop - r0, 1);

    // R5: reset bits are not stored
    axi_write("R5", 6'h00, 32'h0000_0003);
    cap_empty = 1; play_empty = 1;
    axi_read("R5", 6'h00, 0, d);
    chk("R5", "status bits 1:0", {30'b0, d[1:0]}, 0);
    chk("R6", "status both empty", d, 32'h0000_000C);

    // R3: second push with opposite sign halves
    w0 = n_pw;
    axi_write("R3", 6'h04, 32'h7FFF_8001);
    repeat (2) @(negedge clk);
    chk("R3", "push count", n_pw - w0, 1);
    chk("R3", "stereo word", last_pd, 32'h7FFF_8001);

    // R10: interrupt stays low
    chk("R10", "irq", irq, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule